// File: doc/BRIEF.md
# I2C Master Clock Generator with Bus Synchronization

This block produces the serial clock of an I2C master from a fast reference clock. The clock is set by a 16-bit divisor. The block drives the clock line open-drain: one output enables a pull-down, and releasing the line lets the pull-up raise it. The block reads back the real, wired-AND level of the line. Its own clock therefore locks to any other master on the bus, and it waits while a slave holds the line low.

Each phase is timed in reference ticks, where a tick is a cycle with `ref_tick` high. Each phase is timed from the moment the bus is seen in that level, not from a free-running divider. As a result, the longest low period driven by any device sets the bus low time. A low pulled by another device during this block's high phase cuts that high phase short.

The bit engine receives two single-cycle strobes. One marks the start of each low phase, which is the moment to change the data line. The other marks the moment the line is seen high, which is the moment to sample the data line. A divisor below the minimum for the selected bus mode raises an error flag and stops all clock generation.

Top module: `scl_clkgen`

## Requirements
- R1: `cfg_err` is high exactly when `divisor` < 4 with `multi_master`=0, or `divisor` < 8 with `multi_master`=1. While it is high, the block never pulls the line and gives no strobes.
- R2: With an even divisor D, a tick every cycle and no other device driving, each bus low phase lasts D/2 cycles.
- R3: With an odd divisor D, a tick every cycle and no other device driving, each bus low phase lasts (D-1)/2 cycles.
- R4: After its low count ends, the block releases the line. It starts its high count only once a two-flop synchronized copy of `scl_in` reads high. With a tick every cycle and no other device driving, the bus high phase therefore lasts D/2 + 3 cycles for even D and (D-1)/2 + 3 cycles for odd D. `rise_stb` is given only while the line is released.
- R5: When another device holds the line low for longer than this block's own low count, the bus low time equals that device's low time. The following high phase still has the full length from R4.
- R6: A low on `scl_in` seen while the block is counting its high phase ends that phase at once. The block then pulls the line in the third cycle after the low is presented, with `fall_stb` high, and holds it for a full low count.
- R7: After reset, and whenever `enable` is low, `scl_pull`, `rise_stb` and `fall_stb` are all low and the phase counter is cleared.
- R8: `fall_stb` is high for exactly the first cycle of each period in which `scl_pull` is high. There is exactly one `fall_stb` and one `rise_stb` per bus clock period, and the two strobes are never high together.
- R9: Phase counters advance only on cycles with `ref_tick` high. With no ticks the current phase holds, and with a tick every other cycle each phase lasts about twice as many cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Count enable: one reference tick |
| divisor | input | 16 | Clock division factor |
| multi_master | input | 1 | 1 selects multi-master limits (minimum divisor 8) |
| enable | input | 1 | Run request: block acts as clock master |
| scl_in | input | 1 | Sampled level of the clock line (asynchronous) |
| scl_pull | output | 1 | 1 pulls the clock line low; 0 releases it |
| rise_stb | output | 1 | One-cycle strobe when the line is seen high |
| fall_stb | output | 1 | One-cycle strobe on entry to a low phase |
| cfg_err | output | 1 | Divisor below the minimum for the selected mode |

## Verification
The hardest case to reach is another device pulling the line low while this block is partway through its own high count. The early low must land after the synchronizer has already reported the line high. The bench waits for `rise_stb`, lets two more cycles pass, and then drives an extra pull-down into the modelled wired-AND line. It then checks that the block's pull-down starts three cycles later and lasts a full low count. Clock stretching is reached through a second open-drain device model that answers every falling edge with a longer low of its own.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
    localparam int unsigned DIV_W = 16;
    localparam int unsigned CNT_W = DIV_W - 1;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_LOW     = 2'd1,
        PH_WAIT_HI = 2'd2,
        PH_HIGH    = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic               rise;
        logic               fall;
    } gen_state_t;
endpackage

// File: rtl/scl_in_sync.sv
module scl_in_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/scl_div_check.sv
module scl_div_check #(
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned MIN_SINGLE = 4,
    parameter int unsigned MIN_MULTI  = 8
) (
    input  logic [DIV_W-1:0] divisor,
    input  logic             multi_master,
    output logic [DIV_W-2:0] half_len,
    output logic             bad_cfg
);
    localparam logic [DIV_W-1:0] LIM_S = DIV_W'(MIN_SINGLE);
    localparam logic [DIV_W-1:0] LIM_M = DIV_W'(MIN_MULTI);

    logic [DIV_W-1:0] limit;

    always_comb begin
        limit    = multi_master ? LIM_M : LIM_S;
        bad_cfg  = (divisor < limit);
        // floor(D/2) covers both even and odd divisors
        half_len = divisor[DIV_W-1:1];
    end
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_gen_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_SINGLE  = 4,
    parameter int unsigned MIN_MULTI   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic [DIV_W-1:0] divisor,
    input  logic             multi_master,
    input  logic             enable,
    input  logic             scl_in,
    output logic             scl_pull,
    output logic             rise_stb,
    output logic             fall_stb,
    output logic             cfg_err
);
    logic             bus_hi;
    logic [CNT_W-1:0] half_len;
    logic [CNT_W-1:0] last_cnt;
    logic             bad_cfg;
    logic             run;
    logic             done;

    gen_state_t cur_q, nxt_d;

    scl_in_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (scl_in),
        .sync_out (bus_hi)
    );

    scl_div_check #(
        .DIV_W      (DIV_W),
        .MIN_SINGLE (MIN_SINGLE),
        .MIN_MULTI  (MIN_MULTI)
    ) chk_cfg_i (
        .divisor      (divisor),
        .multi_master (multi_master),
        .half_len     (half_len),
        .bad_cfg      (bad_cfg)
    );

    always_comb begin
        run      = enable && !bad_cfg;
        last_cnt = half_len - CNT_W'(1);
        done     = (cur_q.cnt >= last_cnt);

        nxt_d      = cur_q;
        nxt_d.rise = 1'b0;
        nxt_d.fall = 1'b0;

        if (!run) begin
            nxt_d.phase = PH_IDLE;
            nxt_d.cnt   = '0;
        end else begin
            unique case (cur_q.phase)
                PH_IDLE: begin
                    nxt_d.phase = PH_LOW;
                    nxt_d.cnt   = '0;
                    nxt_d.fall  = 1'b1;
                end
                PH_LOW: begin
                    if (ref_tick) begin
                        if (done) begin
                            nxt_d.phase = PH_WAIT_HI;
                            nxt_d.cnt   = '0;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                        end
                    end
                end
                PH_WAIT_HI: begin
                    // line released; high count waits for the bus itself
                    if (bus_hi) begin
                        nxt_d.phase = PH_HIGH;
                        nxt_d.cnt   = '0;
                        nxt_d.rise  = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (!bus_hi) begin
                        // another device started a low: follow it now
                        nxt_d.phase = PH_LOW;
                        nxt_d.cnt   = '0;
                        nxt_d.fall  = 1'b1;
                    end else if (ref_tick) begin
                        if (done) begin
                            nxt_d.phase = PH_LOW;
                            nxt_d.cnt   = '0;
                            nxt_d.fall  = 1'b1;
                        end else begin
                            nxt_d.cnt = cur_q.cnt + CNT_W'(1);
                        end
                    end
                end
                default: begin
                    nxt_d.phase = PH_IDLE;
                    nxt_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_IDLE, cnt: '0, rise: 1'b0, fall: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign scl_pull = (cur_q.phase == PH_LOW);
    assign rise_stb = cur_q.rise;
    assign fall_stb = cur_q.fall;
    assign cfg_err  = bad_cfg;
endmodule

// File: rtl/scl_clkgen_chk.sv
module scl_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_tick,
    input logic enable,
    input logic cfg_err,
    input logic scl_pull,
    input logic rise_stb,
    input logic fall_stb
);
    assert_err_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> (!scl_pull && !fall_stb && !rise_stb));

    assert_rise_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |-> !scl_pull);

    assert_disabled_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_pull && !rise_stb && !fall_stb));

    assert_fall_in_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |-> scl_pull);

    assert_pull_start_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> fall_stb);

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb));

    assert_no_tick_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tick && scl_pull && enable && !cfg_err) |=> scl_pull);
endmodule

bind scl_clkgen scl_clkgen_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_tick (ref_tick),
    .enable   (enable),
    .cfg_err  (cfg_err),
    .scl_pull (scl_pull),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
);

// File: tb/scl_clkgen_tb_top.sv
`timescale 1ns/1ps
module scl_clkgen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic [15:0] divisor = 16'd10;
    logic        multi_master = 1'b0;
    logic        enable = 1'b0;
    logic        scl_pull, rise_stb, fall_stb, cfg_err;
    logic        other_pull = 1'b0;
    logic        ext_low = 1'b0;
    logic        bus_lvl;

    int n_checks = 0;
    int n_fail   = 0;
    int other_len = 0;
    int other_cnt = 0;
    bit prev_bus = 1'b1;
    bit tick_alt = 1'b0;

    always #4 clk = ~clk;

    assign bus_lvl = !(scl_pull || other_pull || ext_low);

    scl_clkgen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_tick     (ref_tick),
        .divisor      (divisor),
        .multi_master (multi_master),
        .enable       (enable),
        .scl_in       (bus_lvl),
        .scl_pull     (scl_pull),
        .rise_stb     (rise_stb),
        .fall_stb     (fall_stb),
        .cfg_err      (cfg_err)
    );

    // second open-drain device: answers each falling edge with its own low
    always @(negedge clk) begin
        if (other_len > 0 && prev_bus && !bus_lvl && !other_pull) begin
            other_pull = 1'b1;
            other_cnt  = other_len;
        end else if (other_pull) begin
            other_cnt = other_cnt - 1;
            if (other_cnt <= 0) other_pull = 1'b0;
        end
        prev_bus = !(scl_pull || other_pull || ext_low);
        if (tick_alt) ref_tick <= ~ref_tick;
        else          ref_tick <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sample();
        @(negedge clk);
        #1;
    endtask

    task automatic configure(input int d, input bit mm);
        enable = 1'b0;
        repeat (4) sample();
        divisor      = 16'(d);
        multi_master = mm;
        enable       = 1'b1;
    endtask

    task automatic measure(output int lo, output int hi, output int nf, output int nr);
        int g;
        lo = 0; hi = 0; nf = 0; nr = 0; g = 0;
        sample();
        while (!bus_lvl && g < 5000) begin sample(); g++; end
        while (bus_lvl && g < 5000)  begin sample(); g++; end
        while (!bus_lvl && g < 5000) begin lo++; nf += int'(fall_stb); sample(); g++; end
        while (bus_lvl && g < 5000)  begin hi++; nr += int'(rise_stb); sample(); g++; end
        if (g >= 5000) check(1'b0, "measure timeout", g, 0);
    endtask

    task automatic t_reset();
        sample();
        check(scl_pull == 1'b0, "R7 reset pull", int'(scl_pull), 0);
        check(!rise_stb && !fall_stb, "R7 reset strobes", int'(rise_stb || fall_stb), 0);
        check(cfg_err == 1'b0, "R1 no error at D=10", int'(cfg_err), 0);
    endtask

    task automatic t_disabled();
        int seen = 0;
        enable = 1'b0;
        repeat (60) begin sample(); seen += int'(scl_pull || rise_stb || fall_stb); end
        check(seen == 0, "R7 disabled stays quiet", seen, 0);
    endtask

    task automatic t_period(input int d, input bit mm, input string req);
        int lo, hi, nf, nr, h;
        h = d / 2;
        configure(d, mm);
        repeat (2) begin
            measure(lo, hi, nf, nr);
            check(lo == h, req, lo, h);
            check(hi == h + 3, {req, " R4 high"}, hi, h + 3);
            check(nf == 1 && nr == 1, "R8 one strobe each", nf * 10 + nr, 11);
        end
    endtask

    task automatic t_cfg_err(input int d, input bit mm, input bit exp_err);
        int seen = 0;
        configure(d, mm);
        sample();
        check(cfg_err == exp_err, "R1 error flag", int'(cfg_err), int'(exp_err));
        if (exp_err) begin
            repeat (50) begin sample(); seen += int'(scl_pull || fall_stb || rise_stb); end
            check(seen == 0, "R1 no clock on error", seen, 0);
        end
    endtask

    task automatic t_stretch();
        int lo, hi, nf, nr;
        other_len = 23;
        configure(10, 1'b0);
        repeat (2) begin
            measure(lo, hi, nf, nr);
            check(lo == 23, "R5 stretched low", lo, 23);
            check(hi == 8, "R5 high after stretch", hi, 8);
        end
        other_len = 0;
        repeat (30) sample();
    endtask

    task automatic t_early_pull();
        int g = 0;
        int len = 0;
        configure(20, 1'b0);
        sample();
        while (!rise_stb && g < 2000) begin sample(); g++; end
        repeat (2) sample();
        check(scl_pull == 1'b0, "R6 in high phase", int'(scl_pull), 0);
        ext_low = 1'b1;
        repeat (2) sample();
        check(scl_pull == 1'b0, "R6 not before sync", int'(scl_pull), 0);
        sample();
        check(scl_pull == 1'b1, "R6 pull after 3 cycles", int'(scl_pull), 1);
        check(fall_stb == 1'b1, "R6 fall strobe", int'(fall_stb), 1);
        ext_low = 1'b0;
        while (scl_pull && len < 100) begin len++; sample(); end
        check(len == 10, "R6 full low count", len, 10);
    endtask

    task automatic t_tick();
        int lo, hi, nf, nr, held;
        tick_alt = 1'b1;
        configure(8, 1'b1);
        measure(lo, hi, nf, nr);
        check(lo == 7 || lo == 8, "R9 half-rate low", lo, 8);
        check(hi == 10 || hi == 11, "R9 half-rate high", hi, 11);
        tick_alt = 1'b0;
        while (!scl_pull) sample();
        #2 ref_tick = 1'b0;
        tick_alt = 1'b0;
        held = 0;
        force ref_tick = 1'b0;
        repeat (40) begin sample(); held += int'(scl_pull); end
        release ref_tick;
        check(held == 40, "R9 no tick holds phase", held, 40);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_period(10, 1'b0, "R2 even low D=10");
        t_period(11, 1'b0, "R3 odd low D=11");
        t_period(4,  1'b0, "R2 minimum single D=4");
        t_period(9,  1'b1, "R3 odd multi D=9");
        t_cfg_err(3, 1'b0, 1'b1);
        t_cfg_err(7, 1'b1, 1'b1);
        t_cfg_err(4, 1'b0, 1'b0);
        t_cfg_err(8, 1'b1, 1'b0);
        t_stretch();
        t_early_pull();
        t_tick();
        t_disabled();
        finish_run();
    end
endmodule